// File: doc/BRIEF.md
# Double-Buffered Timer PWM Generator

This block makes a pulse-width-modulated waveform from a free-running timer. A prescaler divides the bus clock by a power of two. The divided clock advances an up-counter. The counter climbs from zero to a programmable modulo value and then wraps to zero. Each wrap starts a new PWM period and drives the output high. The output goes low when the counter reaches the pulse-width value that is in control at that moment.

Two pulse-width registers exist. When they are unlinked, only the first one matters, and a new value written to it is used at once. A write at the wrong moment in the period can therefore miss the compare for that period. When they are linked, the two registers act as a ping-pong pair. At each wrap, the output is handed to whichever register software wrote most recently. Software can prepare the next duty value at any point in the period without producing a glitch.

Top module: `dbuf_pwm_timer`

## Requirements
- R1: While reset is asserted and just after it is released, `pwmOut`, `ovfFlag` and `cmpFlag` are all 0. At reset the modulo register holds all ones, the prescaler code is 0, both channel values are 0 and the channels are unlinked.
- R2: With prescaler code 0 the counter advances on every clock, so a modulo of M gives a period of M+1 clocks. A modulo of 255 gives 256 clocks.
- R3: Prescaler code k (0 to 6) advances the counter once every 2^k clocks. Code 7 behaves exactly like code 6. Between advances the counter holds its value.
- R4: `ovfFlag` is high for one clock after each counter step that wraps the count from the modulo value (or above) to 0.
- R5: The output is set when the counter wraps and is cleared when the counter steps onto the controlling channel value D. With 0 < D <= M it is high for D·2^k clocks per period. D = 128 with M = 255 gives exactly half.
- R6: A controlling value of 0 keeps the output low for the whole period. A value greater than the modulo keeps it high for the whole period.
- R7: `cmpFlag` is high for one clock after each counter step that lands on the controlling channel value. The output is low in that clock.
- R8: When unlinked, channel 0 alone controls the output and a write to it applies from the next clock. A write below the present count misses the compare, so the output stays high until the wrap. Writes to channel 1 do not change the output.
- R9: Writing the link register (either value) returns control to channel 0 from the next clock and counts channel 0 as most recently written.
- R10: When linked, a write to channel 1 does not change the current period. Channel 1 takes control at the next wrap.
- R11: When linked, at every wrap the controlling register becomes the one of the pair written most recently.
- R12: The write map is: address 0 modulo, address 1 prescaler code (bits 2:0), address 2 channel 0, address 3 channel 1, address 4 link enable (bit 0). Writes to addresses 5 to 7 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 3 | Register address |
| wrData | input | 16 | Write data |
| pwmOut | output | 1 | PWM waveform |
| ovfFlag | output | 1 | One-clock pulse on counter wrap |
| cmpFlag | output | 1 | One-clock pulse on compare match |

## Verification
The assertions check the relations that hold on every clock:
- a wrap flag appears only with a zero count;
- a compare flag is never seen with the output high;
- the count is frozen between prescaler ticks;
- control stays on channel 0 while unlinked;
- ownership changes only at a wrap or a link write, and a wrap hands control to the register written last.

Only the bench scenarios can show the period lengths, the duty counts for each prescaler code, the missed compare after a late unlinked write, and that a channel 1 write waits for the next period.

// File: rtl/dbuf_pwm_pkg.sv
package dbuf_pwm_pkg;
  parameter int CNT_W       = 16;
  parameter int ADDR_W      = 3;
  parameter int PSC_SEL_W   = 3;
  parameter int PSC_MAX_LOG = 6;

  localparam logic [ADDR_W-1:0] ADR_MOD  = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] ADR_PSC  = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] ADR_CH0  = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] ADR_CH1  = ADDR_W'(3);
  localparam logic [ADDR_W-1:0] ADR_LINK = ADDR_W'(4);

  typedef struct packed {
    logic ldMod;
    logic ldPsc;
    logic ldCh0;
    logic ldCh1;
  } wrStrobe_t;
endpackage

// File: rtl/dbuf_pwm_ctrl.sv
module dbuf_pwm_ctrl
  import dbuf_pwm_pkg::*;
#(
  parameter int AW = ADDR_W
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          wrEn,
  input  logic [AW-1:0] wrAddr,
  input  logic          linkBit,
  input  logic          wrapTick,
  output wrStrobe_t     strb,
  output logic          useCh1
);
  logic linkEn, selQ, lastWr, ldLink;

  always_comb begin
    strb.ldMod = wrEn && (wrAddr == AW'(ADR_MOD));
    strb.ldPsc = wrEn && (wrAddr == AW'(ADR_PSC));
    strb.ldCh0 = wrEn && (wrAddr == AW'(ADR_CH0));
    strb.ldCh1 = wrEn && (wrAddr == AW'(ADR_CH1));
    ldLink     = wrEn && (wrAddr == AW'(ADR_LINK));
  end

  // owner for the compare this clock: swaps only on wrap
  always_comb useCh1 = wrapTick ? (linkEn && lastWr) : selQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      linkEn <= 1'b0;
      selQ   <= 1'b0;
      lastWr <= 1'b0;
    end else begin
      selQ <= useCh1;
      if (strb.ldCh0) lastWr <= 1'b0;
      if (strb.ldCh1) lastWr <= 1'b1;
      if (ldLink) begin
        linkEn <= linkBit;
        selQ   <= 1'b0;
        lastWr <= 1'b0;
      end
    end
  end

  p_unlinked_ch0_r8: assert property (@(posedge clk) disable iff (!rstN)
    !linkEn |-> !selQ);
  p_link_restart_r9: assert property (@(posedge clk) disable iff (!rstN)
    ldLink |=> !selQ);
  p_owner_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    (!wrapTick && !ldLink) |=> $stable(selQ));
  p_owner_last_r11: assert property (@(posedge clk) disable iff (!rstN)
    (wrapTick && linkEn && !ldLink) |=> (selQ == $past(lastWr)));
endmodule

// File: rtl/dbuf_pwm_dp.sv
module dbuf_pwm_dp
  import dbuf_pwm_pkg::*;
#(
  parameter int CW     = CNT_W,
  parameter int SW     = PSC_SEL_W,
  parameter int MAXLOG = PSC_MAX_LOG
) (
  input  logic          clk,
  input  logic          rstN,
  input  wrStrobe_t     strb,
  input  logic          useCh1,
  input  logic [CW-1:0] wrData,
  output logic          wrapTick,
  output logic          pwmOut,
  output logic          ovfFlag,
  output logic          cmpFlag
);
  localparam int PCW = (MAXLOG > 0) ? MAXLOG : 1;

  logic [CW-1:0] modQ, ch0Q, ch1Q, cnt, cntNext, activeVal;
  logic [SW-1:0] pscSelQ;
  logic          tick, hit, pwmQ, ovfQ, cmpQ;

  generate
    if (MAXLOG == 0) begin : g_noPsc
      assign tick = 1'b1;
    end else begin : g_psc
      logic [PCW-1:0] pscCnt, pscMask;
      logic [SW-1:0]  effLog;
      always_comb begin
        effLog  = (int'(pscSelQ) > MAXLOG) ? SW'(MAXLOG) : pscSelQ;
        pscMask = (PCW'(1) << effLog) - PCW'(1);
      end
      assign tick = ((pscCnt & pscMask) == pscMask);
      always_ff @(posedge clk) begin
        if (!rstN) pscCnt <= '0;
        else       pscCnt <= pscCnt + PCW'(1);
      end
    end
  endgenerate

  always_comb begin
    wrapTick  = tick && (cnt >= modQ);
    cntNext   = wrapTick ? '0 : cnt + CW'(1);
    activeVal = useCh1 ? ch1Q : ch0Q;
    hit       = (cntNext == activeVal);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      modQ <= '1; pscSelQ <= '0; ch0Q <= '0; ch1Q <= '0;
      cnt <= '0; pwmQ <= 1'b0; ovfQ <= 1'b0; cmpQ <= 1'b0;
    end else begin
      ovfQ <= wrapTick;
      cmpQ <= tick && hit;
      if (tick) begin
        cnt <= cntNext;
        if (hit)           pwmQ <= 1'b0;
        else if (wrapTick) pwmQ <= (activeVal != '0);
      end
      if (strb.ldMod) modQ    <= wrData;
      if (strb.ldPsc) pscSelQ <= wrData[SW-1:0];
      if (strb.ldCh0) ch0Q    <= wrData;
      if (strb.ldCh1) ch1Q    <= wrData;
    end
  end

  assign pwmOut  = pwmQ;
  assign ovfFlag = ovfQ;
  assign cmpFlag = cmpQ;

  p_ovf_zero_r4: assert property (@(posedge clk) disable iff (!rstN)
    ovfQ |-> (cnt == '0));
  p_cmp_low_r7: assert property (@(posedge clk) disable iff (!rstN)
    cmpQ |-> !pwmQ);
  p_cnt_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    !tick |=> $stable(cnt));
  p_full_duty_r6: assert property (@(posedge clk) disable iff (!rstN)
    (wrapTick && (activeVal > modQ)) |=> pwmQ);
endmodule

// File: rtl/dbuf_pwm_timer.sv
module dbuf_pwm_timer
  import dbuf_pwm_pkg::*;
#(
  parameter int CW     = CNT_W,
  parameter int AW     = ADDR_W,
  parameter int SW     = PSC_SEL_W,
  parameter int MAXLOG = PSC_MAX_LOG
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          wrEn,
  input  logic [AW-1:0] wrAddr,
  input  logic [CW-1:0] wrData,
  output logic          pwmOut,
  output logic          ovfFlag,
  output logic          cmpFlag
);
  wrStrobe_t strb;
  logic      useCh1, wrapTick;

  dbuf_pwm_ctrl #(.AW(AW)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr),
    .linkBit(wrData[0]), .wrapTick(wrapTick), .strb(strb), .useCh1(useCh1)
  );

  dbuf_pwm_dp #(.CW(CW), .SW(SW), .MAXLOG(MAXLOG)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .useCh1(useCh1), .wrData(wrData),
    .wrapTick(wrapTick), .pwmOut(pwmOut), .ovfFlag(ovfFlag), .cmpFlag(cmpFlag)
  );
endmodule

// File: tb/dbuf_pwm_timer_test.sv
module dbuf_pwm_timer_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [2:0]  wrAddr = '0;
  logic [15:0] wrData = '0;
  logic        pwmOut, ovfFlag, cmpFlag;
  int          errors = 0, checks = 0, cyc = 0;

  always #10 clk = ~clk;

  dbuf_pwm_timer uut (.clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData), .pwmOut(pwmOut), .ovfFlag(ovfFlag), .cmpFlag(cmpFlag));

  // reference state
  int  mMod = 16'hFFFF, mCode = 0, mCh0 = 0, mCh1 = 0, mPsc = 0, mCnt = 0;
  bit  mLink = 0, mOwn = 0, mLast = 0, mPwm = 0, mOvf = 0, mCmp = 0;

  task automatic check(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic bit pscTick(int code, int p);
    int e = (code > 6) ? 6 : code;
    return (p % (1 << e)) == ((1 << e) - 1);
  endfunction

  task automatic modelStep(bit we, int a, int d);
    bit tk = pscTick(mCode, mPsc);
    bit wr = tk && (mCnt >= mMod);
    bit u  = wr ? (mLink && mLast) : mOwn;
    int v  = u ? mCh1 : mCh0;
    int nc = wr ? 0 : mCnt + 1;
    mPsc = (mPsc + 1) % 64;
    mOvf = wr;
    mCmp = tk && (nc == v);
    if (tk) begin
      mCnt = nc;
      if (nc == v) mPwm = 0;
      else if (wr) mPwm = (v != 0);
    end
    mOwn = u;
    if (we) begin
      case (a)
        0: mMod = d;
        1: mCode = d & 7;
        2: begin mCh0 = d; mLast = 0; end
        3: begin mCh1 = d; mLast = 1; end
        4: begin mLink = d[0]; mOwn = 0; mLast = 0; end
        default: ;
      endcase
    end
  endtask

  task automatic step(bit we, int a, int d);
    wrEn = we; wrAddr = 3'(a); wrData = 16'(d);
    @(posedge clk);
    modelStep(we, a, d);
    @(negedge clk);
    wrEn = 1'b0;
    check(pwmOut == mPwm, "R5 pwmOut", pwmOut, mPwm);
    check(ovfFlag == mOvf, "R4 ovfFlag", ovfFlag, mOvf);
    check(cmpFlag == mCmp, "R7 cmpFlag", cmpFlag, mCmp);
  endtask

  task automatic syncOvf();
    int n = 0;
    do begin step(0, 0, 0); n++; end while (!ovfFlag && n < 40000);
  endtask

  // full period after the next wrap: length and high clocks
  task automatic measure(output int len, output int high);
    syncOvf();
    len = 0; high = 0;
    do begin
      high += pwmOut; len++;
      step(0, 0, 0);
    end while (!ovfFlag && len < 40000);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000) begin
      errors++; checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 190000);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int len, high, rem, remHigh;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    check(pwmOut == 0 && ovfFlag == 0 && cmpFlag == 0, "R1 reset outputs", pwmOut, 0);
    rstN = 1'b1;
    step(0, 0, 0);
    check(pwmOut == 0, "R1 after release", pwmOut, 0);

    step(1, 5, 16'h1234); step(1, 7, 3);   // R12 unmapped writes ignored
    step(1, 0, 255); step(1, 1, 0); step(1, 2, 128);
    measure(len, high);
    check(len == 256, "R2 period code0 M255", len, 256);
    check(high == 128, "R5 half duty", high, 128);

    step(1, 1, 2); step(1, 0, 9); step(1, 2, 3);
    measure(len, high); measure(len, high);
    check(len == 40, "R3 period code2", len, 40);
    check(high == 12, "R5 duty code2", high, 12);

    step(1, 1, 7); step(1, 0, 3); step(1, 2, 2);
    measure(len, high); measure(len, high);
    check(len == 256, "R3 code7 as code6", len, 256);
    check(high == 128, "R3 duty code7", high, 128);

    step(1, 1, 0); step(1, 0, 9); step(1, 2, 0);
    measure(len, high); measure(len, high);
    check(high == 0, "R6 zero duty", high, 0);
    step(1, 2, 20);
    measure(len, high); measure(len, high);
    check(high == 10, "R6 full duty", high, 10);

    step(1, 2, 4); step(1, 3, 8);
    measure(len, high); measure(len, high);
    check(high == 4, "R8 ch1 ignored unlinked", high, 4);

    step(1, 0, 99); step(1, 2, 80);
    measure(len, high);
    repeat (60) step(0, 0, 0);
    step(1, 2, 30);
    rem = 0; remHigh = 0;
    do begin remHigh += pwmOut; rem++; step(0, 0, 0); end while (!ovfFlag && rem < 400);
    check(remHigh == rem, "R8 missed compare keeps high", remHigh, rem);
    len = 0; high = 0;
    do begin high += pwmOut; len++; step(0, 0, 0); end while (!ovfFlag && len < 400);
    check(high == 30, "R8 new value next period", high, 30);
    repeat (5) step(0, 0, 0);
    step(1, 2, 70);
    rem = 0; remHigh = 0;
    do begin remHigh += pwmOut; rem++; step(0, 0, 0); end while (!ovfFlag && rem < 400);
    check(remHigh == 64, "R8 immediate in-period effect", remHigh, 64);

    step(1, 4, 1); step(1, 2, 20);
    measure(len, high);
    check(high == 20, "R9 ch0 controls after link", high, 20);
    repeat (30) step(0, 0, 0);
    step(1, 3, 70);
    rem = 0; remHigh = 0;
    do begin remHigh += pwmOut; rem++; step(0, 0, 0); end while (!ovfFlag && rem < 400);
    check(remHigh == 0, "R10 ch1 waits for wrap", remHigh, 0);
    len = 0; high = 0;
    do begin high += pwmOut; len++; step(0, 0, 0); end while (!ovfFlag && len < 400);
    check(high == 70, "R10 ch1 in control", high, 70);
    step(1, 2, 10);
    measure(len, high);
    check(high == 10, "R11 back to ch0", high, 10);
    step(1, 3, 50);
    measure(len, high);
    check(high == 50, "R11 ch1 again", high, 50);
    step(1, 4, 0);
    measure(len, high);
    check(high == 10, "R9 unlink returns ch0", high, 10);

    // constrained random phase, checked each clock against the reference
    for (int i = 0; i < 6000; i++) begin
      if ($urandom % 16 == 0) begin
        int a = $urandom % 8;
        int d;
        case (a)
          0: d = 2 + $urandom % 30;
          1: d = ($urandom % 4 == 0) ? $urandom % 8 : $urandom % 3;
          2, 3: d = $urandom % 40;
          4: d = $urandom % 2;
          default: d = $urandom;
        endcase
        step(1, a, d);
      end else step(0, 0, 0);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule